// File: doc/BRIEF.md
# Two-Wire Debug Host Engine

This block is the host end of a two-wire serial debug link. It produces the debug clock and owns one bidirectional data line. The line carries the host's command, then the target's answer, then the data word, so the block controls the line's output enable. A client hands it one request at a time: a port select, a direction, a 2-bit register address and, for writes, a 32-bit word. The engine walks the line through the whole exchange. It builds the request byte with its parity bit, releases the line for the turnaround and reads the three-bit acknowledge. It then either drives the write word with parity or collects the read word and checks its parity. At the end it reports a status and any read data.

The debug clock is divided down from the system clock by a ratio set at a port. The engine samples the data line as the debug clock rises and changes what it drives as the clock falls. Between transactions it holds the line low as idle bits, and it accepts no new request until a set number of idle bits have gone by. A wait, fault or malformed acknowledge cancels the data phase. After one turnaround bit the engine reports the outcome, so the client can retry.

Top module: `swd_host_engine`

## Requirements
- R1: The request goes out as 8 bits, least significant first, in this order: 1 (start), port select, direction (1 = read), address bit 0, address bit 1, even parity over those four bits, 0 (stop), 1 (park).
- R2: Each half period of the debug clock lasts clk_div+1 system cycles, and the host's data output and output enable change only in the cycle where the debug clock falls.
- R3: After the park bit the host releases the line (output enable low) for one turnaround bit and keeps it released through the three acknowledge bits. For a read it also releases the line through the data and parity bits and one trailing turnaround bit.
- R4: The acknowledge is read first bit first. Reading it that way, 3'b001 is OK, 3'b010 is WAIT and 3'b100 is FAULT, and these report status 0, 1 and 2. Any other value reports status 3 (protocol error). For every non-OK acknowledge no data bits are moved, read data reports zero, and the line is released for one turnaround bit before idle.
- R5: A write with an OK acknowledge is followed by one released turnaround bit. The host then drives the 32 data bits, least significant first, and then their even parity bit. The write reports status 0 with zero read data.
- R6: A read with an OK acknowledge samples 32 data bits, least significant first, and then a parity bit. When the parity matches, it returns the word on rsp_rdata with status 0.
- R7: A read whose received parity bit differs from the even parity of the received word reports status 4 (parity error) and still returns the received word.
- R8: Between transactions the host drives the line low with output enable high. req_ready is low in the cycle of the response and stays low until IDLE_BITS idle bits have completed.
- R9: Each accepted request yields exactly one single-cycle rsp_valid pulse, and req_ready is low from the cycle after acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | Debug clock half period minus one, in system cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can accept a request |
| req_ap | input | 1 | Port select bit of the request |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 3 | 0 OK, 1 WAIT, 2 FAULT, 3 protocol error, 4 parity error |
| rsp_rdata | output | 32 | Read data |
| swclk | output | 1 | Debug clock |
| swdio_i | input | 1 | Data line as seen at the pin |
| swdio_o | output | 1 | Value the host drives on the data line |
| swdio_oe | output | 1 | Host output enable for the data line |

## Verification
The assertions assume that clk_div changes only while the engine is idle and that the target never needs the host to wait beyond the fixed bit sequence. They also assume req_valid is offered only as a plain request, so only the engine's own behaviour is checked. The bench changes clk_div only before it offers a request, drives swdio_i only on falling debug clock edges so that the value is stable at every rising edge, and holds swdio_i at zero whenever the host owns the line. Random transactions mix directions, addresses, data, all acknowledge outcomes and corrupted read parity.

// File: rtl/swd_pkg.sv
package swd_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    ST_OK     = 3'd0,
    ST_WAIT   = 3'd1,
    ST_FAULT  = 3'd2,
    ST_PROTO  = 3'd3,
    ST_PARITY = 3'd4
  } swd_status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQ,
    PH_TRN_A,
    PH_ACK,
    PH_RDAT,
    PH_TRN_B,
    PH_WDAT
  } swd_phase_e;

  // even parity over the four request fields
  function automatic logic req_parity(logic ap, logic rnw, logic [1:0] addr);
    return ap ^ rnw ^ addr[0] ^ addr[1];
  endfunction

  // request byte, bit 0 leaves the host first
  function automatic logic [7:0] build_req(logic ap, logic rnw, logic [1:0] addr);
    return {1'b1, 1'b0, req_parity(ap, rnw, addr), addr[1], addr[0], rnw, ap, 1'b1};
  endfunction

  function automatic logic word_parity(logic [WORD_W-1:0] w);
    return ^w;
  endfunction

  // ack bit 0 is the first bit received
  function automatic swd_status_e decode_ack(logic [2:0] ack);
    case (ack)
      3'b001:  return ST_OK;
      3'b010:  return ST_WAIT;
      3'b100:  return ST_FAULT;
      default: return ST_PROTO;
    endcase
  endfunction

endpackage

// File: rtl/swd_clkgen.sv
module swd_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             swclk,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] half_cnt;
  logic             tick;

  assign tick     = (half_cnt >= div);
  assign rise_evt = tick && !swclk;
  assign fall_evt = tick && swclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt <= '0;
      swclk    <= 1'b0;
    end else if (tick) begin
      half_cnt <= '0;
      swclk    <= ~swclk;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/swd_seq.sv
module swd_seq
  import swd_pkg::*;
#(
  parameter int IDLE_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ap,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [2:0]        rsp_status,
  output logic [WORD_W-1:0] rsp_rdata,
  input  logic              din,
  output logic              dout,
  output logic              doe,
  output logic              idle_phase
);

  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int IDLE_W = $clog2(IDLE_BITS + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0]  REQ_LAST  = CNT_W'(7);
  localparam logic [CNT_W-1:0]  ACK_LAST  = CNT_W'(2);
  localparam logic [IDLE_W-1:0] IDLE_NEED = IDLE_W'(IDLE_BITS);

  swd_phase_e        phase;
  logic [CNT_W-1:0]  cnt;
  logic [IDLE_W-1:0] idle_cnt;
  logic              pend;
  logic [7:0]        pkt_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] rdata_q;
  logic              rnw_q;
  logic              rpar_q;
  logic [2:0]        ack_q;
  logic              wr_next;
  swd_status_e       status_q;
  logic              accept;

  assign idle_phase = (phase == PH_IDLE);
  assign req_ready  = idle_phase && !pend && !rsp_valid && (idle_cnt >= IDLE_NEED);
  assign accept     = req_valid && req_ready;

  always_comb begin
    dout = 1'b0;
    doe  = 1'b0;
    case (phase)
      PH_IDLE: begin
        doe  = 1'b1;
        dout = 1'b0;
      end
      PH_REQ: begin
        doe  = 1'b1;
        dout = pkt_q[cnt[2:0]];
      end
      PH_WDAT: begin
        doe  = 1'b1;
        dout = (cnt == LAST_BIT) ? word_parity(wdata_q) : wdata_q[cnt[4:0]];
      end
      default: begin
        doe  = 1'b0;
        dout = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      idle_cnt   <= '0;
      pend       <= 1'b0;
      pkt_q      <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      rnw_q      <= 1'b0;
      rpar_q     <= 1'b0;
      ack_q      <= '0;
      wr_next    <= 1'b0;
      status_q   <= ST_OK;
      rsp_valid  <= 1'b0;
      rsp_status <= '0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;

      if (accept) begin
        pkt_q   <= build_req(req_ap, req_rnw, req_addr);
        wdata_q <= req_wdata;
        rnw_q   <= req_rnw;
        pend    <= 1'b1;
      end

      if (rise_evt) begin
        if (phase == PH_ACK) begin
          ack_q[cnt[1:0]] <= din;
        end else if (phase == PH_RDAT) begin
          if (cnt == LAST_BIT) rpar_q <= din;
          else                 rdata_q <= {din, rdata_q[WORD_W-1:1]};
        end
      end

      if (fall_evt) begin
        case (phase)
          PH_IDLE: begin
            if (pend) begin
              pend    <= 1'b0;
              phase   <= PH_REQ;
              cnt     <= '0;
              rdata_q <= '0;
              ack_q   <= '0;
            end else if (idle_cnt < IDLE_NEED) begin
              idle_cnt <= idle_cnt + 1'b1;
            end
          end
          PH_REQ: begin
            if (cnt == REQ_LAST) phase <= PH_TRN_A;
            else                 cnt   <= cnt + 1'b1;
          end
          PH_TRN_A: begin
            phase <= PH_ACK;
            cnt   <= '0;
          end
          PH_ACK: begin
            if (cnt == ACK_LAST) begin
              status_q <= decode_ack(ack_q);
              cnt      <= '0;
              if (decode_ack(ack_q) == ST_OK && rnw_q) begin
                phase <= PH_RDAT;
              end else begin
                phase   <= PH_TRN_B;
                wr_next <= (decode_ack(ack_q) == ST_OK);
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_RDAT: begin
            if (cnt == LAST_BIT) begin
              phase    <= PH_TRN_B;
              wr_next  <= 1'b0;
              status_q <= (word_parity(rdata_q) == rpar_q) ? ST_OK : ST_PARITY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_TRN_B: begin
            if (wr_next) begin
              phase   <= PH_WDAT;
              cnt     <= '0;
              wr_next <= 1'b0;
            end else begin
              phase      <= PH_IDLE;
              idle_cnt   <= '0;
              rsp_valid  <= 1'b1;
              rsp_status <= status_q;
              rsp_rdata  <= (rnw_q && (status_q == ST_OK || status_q == ST_PARITY))
                            ? rdata_q : '0;
            end
          end
          PH_WDAT: begin
            if (cnt == LAST_BIT) begin
              phase      <= PH_IDLE;
              idle_cnt   <= '0;
              rsp_valid  <= 1'b1;
              rsp_status <= ST_OK;
              rsp_rdata  <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine #(
  parameter int DIV_W     = 8,
  parameter int IDLE_BITS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_ap,
  input  logic             req_rnw,
  input  logic [1:0]       req_addr,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [2:0]       rsp_status,
  output logic [31:0]      rsp_rdata,
  output logic             swclk,
  input  logic             swdio_i,
  output logic             swdio_o,
  output logic             swdio_oe
);

  logic rise_evt;
  logic fall_evt;
  logic idle_phase;

  swd_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .div      (clk_div),
    .swclk    (swclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  swd_seq #(.IDLE_BITS(IDLE_BITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_evt   (rise_evt),
    .fall_evt   (fall_evt),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_ap     (req_ap),
    .req_rnw    (req_rnw),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_rdata  (rsp_rdata),
    .din        (swdio_i),
    .dout       (swdio_o),
    .doe        (swdio_oe),
    .idle_phase (idle_phase)
  );

endmodule

// File: rtl/swd_host_engine_chk.sv
module swd_host_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       swclk,
  input logic       swdio_o,
  input logic       swdio_oe,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic [2:0] rsp_status,
  input logic       idle_phase
);

  // R2
  out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(swdio_o) || !$stable(swdio_oe)) |-> $fell(swclk));

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_phase |-> (swdio_oe && !swdio_o));

  // R8
  no_ready_at_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R4
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status <= 3'd4));

endmodule

bind swd_host_engine swd_host_engine_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .swclk      (swclk),
  .swdio_o    (swdio_o),
  .swdio_oe   (swdio_oe),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_status (rsp_status),
  .idle_phase (idle_phase)
);

// File: tb/tb_swd_host_engine.sv
module tb_swd_host_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  clk_div;
  logic        req_valid;
  logic        req_ready;
  logic        req_ap;
  logic        req_rnw;
  logic [1:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [2:0]  rsp_status;
  logic [31:0] rsp_rdata;
  logic        swclk;
  logic        swdio_i;
  logic        swdio_o;
  logic        swdio_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  swd_host_engine dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_ap(req_ap),
    .req_rnw(req_rnw), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .swclk(swclk), .swdio_i(swdio_i), .swdio_o(swdio_o), .swdio_oe(swdio_oe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_request(logic ap, logic rnw, logic [1:0] a);
    int ones;
    logic [7:0] b;
    ones = int'(ap) + int'(rnw) + int'(a[0]) + int'(a[1]);
    b[0] = 1'b1; b[1] = ap; b[2] = rnw; b[3] = a[0]; b[4] = a[1];
    b[5] = (ones % 2 == 1); b[6] = 1'b0; b[7] = 1'b1;
    return b;
  endfunction

  function automatic logic even_par(logic [31:0] w);
    return ($countones(w) % 2) == 1;
  endfunction

  function automatic logic [2:0] exp_status(logic [2:0] ack, logic rnw, bit bad_par);
    if (ack == 3'b001) return (rnw && bad_par) ? 3'd4 : 3'd0;
    if (ack == 3'b010) return 3'd1;
    if (ack == 3'b100) return 3'd2;
    return 3'd3;
  endfunction

  task automatic run_txn(input logic ap, input logic rnw, input logic [1:0] addr,
                         input logic [31:0] wdata, input logic [31:0] rdata,
                         input logic [2:0] ack, input bit bad_par, input logic [7:0] div);
    logic [7:0]  pkt;
    logic [32:0] wbits;
    bit          idle_bad;
    bit          rel_bad;
    int          n;
    logic [2:0]  st;
    logic [31:0] rd;
    bit          extra;
    bit          ready_seen;
    bit          ok_ack;

    @(negedge clk);
    clk_div = div;
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b1; req_ap = ap; req_rnw = rnw; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    // R9 ready drops after acceptance
    check(req_ready == 1'b0, "R9", "ready after accept", 64'(req_ready), 64'd0);

    idle_bad = 1'b0;
    forever begin
      @(posedge swclk);
      if (swdio_oe && swdio_o) break;
      if (!(swdio_oe && !swdio_o)) idle_bad = 1'b1;
    end
    check(!idle_bad, "R8", "idle line low and driven", 64'(idle_bad), 64'd0);

    n = 0;
    do begin @(negedge clk); n++; end while (swclk);
    check(n == int'(div) + 2, "R2", "high phase length", 64'(n), 64'(int'(div) + 2));

    pkt = 8'h01;
    for (int i = 1; i < 8; i++) begin
      @(posedge swclk);
      pkt[i] = swdio_o;
    end
    check(pkt == exp_request(ap, rnw, addr), "R1", "request byte",
          64'(pkt), 64'(exp_request(ap, rnw, addr)));

    rel_bad = 1'b0;
    @(negedge swclk);
    @(posedge swclk);
    if (swdio_oe) rel_bad = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge swclk);
      swdio_i = ack[i];
      @(posedge swclk);
      if (swdio_oe) rel_bad = 1'b1;
    end
    check(!rel_bad, "R3", "line released in turnaround and ack", 64'(rel_bad), 64'd0);

    ok_ack = (ack == 3'b001);
    if (ok_ack && rnw) begin
      for (int i = 0; i < 33; i++) begin
        @(negedge swclk);
        swdio_i = (i < 32) ? rdata[i] : (even_par(rdata) ^ bad_par);
        @(posedge swclk);
        if (swdio_oe) rel_bad = 1'b1;
      end
      @(negedge swclk);
      swdio_i = 1'b0;
      @(posedge swclk);
      if (swdio_oe) rel_bad = 1'b1;
      check(!rel_bad, "R3", "line released during read data", 64'(rel_bad), 64'd0);
    end else if (ok_ack) begin
      @(negedge swclk);
      swdio_i = 1'b0;
      @(posedge swclk);
      check(swdio_oe == 1'b0, "R5", "write turnaround released", 64'(swdio_oe), 64'd0);
      rel_bad = 1'b0;
      for (int i = 0; i < 33; i++) begin
        @(posedge swclk);
        wbits[i] = swdio_o;
        if (!swdio_oe) rel_bad = 1'b1;
      end
      check(wbits == {even_par(wdata), wdata} && !rel_bad, "R5", "write bits",
            64'(wbits), 64'({even_par(wdata), wdata}));
    end else begin
      @(negedge swclk);
      swdio_i = 1'b0;
      @(posedge swclk);
      check(swdio_oe == 1'b0, "R4", "release after rejected ack", 64'(swdio_oe), 64'd0);
    end

    do @(negedge clk); while (!rsp_valid);
    st = rsp_status;
    rd = rsp_rdata;
    check(req_ready == 1'b0, "R8", "ready low at response", 64'(req_ready), 64'd0);
    if (!ok_ack) begin
      check(st == exp_status(ack, rnw, bad_par) && rd == 32'd0, "R4", "status/data on rejected ack",
            {29'd0, st, rd}, {29'd0, exp_status(ack, rnw, bad_par), 32'd0});
    end else if (!rnw) begin
      check(st == 3'd0 && rd == 32'd0, "R5", "write status", {29'd0, st, rd}, 64'd0);
    end else if (bad_par) begin
      check(st == 3'd4 && rd == rdata, "R7", "parity error status",
            {29'd0, st, rd}, {29'd4, rdata});
    end else begin
      check(st == 3'd0 && rd == rdata, "R6", "read status/data",
            {29'd0, st, rd}, {29'd0, rdata});
    end

    extra = 1'b0;
    ready_seen = 1'b0;
    for (int i = 0; i < 8 * (int'(div) + 1); i++) begin
      @(negedge clk);
      if (rsp_valid) extra = 1'b1;
      if (req_ready) ready_seen = 1'b1;
    end
    check(!extra, "R9", "single response pulse", 64'(extra), 64'd0);
    check(ready_seen, "R8", "ready returns after idle bits", 64'(ready_seen), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] acks [0:4];
    int         seed;
    acks[0] = 3'b001; acks[1] = 3'b010; acks[2] = 3'b100; acks[3] = 3'b000; acks[4] = 3'b111;
    seed = $urandom(32'd1234);

    rst_n = 1'b0; clk_div = 8'd1; req_valid = 1'b0; req_ap = 1'b0; req_rnw = 1'b0;
    req_addr = 2'd0; req_wdata = '0; swdio_i = 1'b0;
    repeat (5) @(negedge clk);
    check(swclk == 1'b0 && swdio_oe == 1'b1 && swdio_o == 1'b0 && rsp_valid == 1'b0,
          "R8", "reset state", {60'd0, swclk, swdio_oe, swdio_o, rsp_valid}, 64'b0100);
    check(req_ready == 1'b0, "R8", "not ready in reset", 64'(req_ready), 64'd0);
    rst_n = 1'b1;

    run_txn(1'b0, 1'b0, 2'd1, 32'hA5C3_0F96, 32'h0, 3'b001, 1'b0, 8'd0);
    run_txn(1'b1, 1'b1, 2'd3, 32'h0, 32'h8000_0001, 3'b001, 1'b0, 8'd1);
    run_txn(1'b1, 1'b1, 2'd2, 32'h0, 32'h1234_5678, 3'b001, 1'b1, 8'd2);
    run_txn(1'b0, 1'b1, 2'd0, 32'h0, 32'hFFFF_FFFF, 3'b010, 1'b0, 8'd0);
    run_txn(1'b1, 1'b0, 2'd1, 32'hFFFF_FFFF, 32'h0, 3'b100, 1'b0, 8'd3);
    run_txn(1'b0, 1'b0, 2'd2, 32'h0000_0001, 32'h0, 3'b000, 1'b0, 8'd1);
    run_txn(1'b0, 1'b1, 2'd3, 32'h0, 32'h0, 3'b111, 1'b0, 8'd0);
    run_txn(1'b0, 1'b1, 2'd0, 32'h0, 32'h0000_0000, 3'b001, 1'b0, 8'd0);

    for (int t = 0; t < 30; t++) begin
      logic [2:0] a;
      a = ($urandom % 3 != 0) ? 3'b001 : acks[$urandom % 5];
      run_txn(1'($urandom), 1'($urandom), 2'($urandom), $urandom, $urandom,
              a, ($urandom % 4 == 0), 8'($urandom % 4));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule